// File: doc/BRIEF.md
# Serial SRAM Target

This block is the target side of a single-lane SPI link that fronts a byte-wide storage array. A host pulls chip select low and shifts in an 8-bit command, MSB first, on rising SCK edges. For data commands a 24-bit address follows. The array has 2^ADDR_W bytes, which is 17 address bits for the full 128K x 8 size. Only the low ADDR_W address bits are used. Write data is then shifted in, or read data is shifted out on the falling SCK edge. An internal pointer moves on after each byte according to a two-bit mode register: single byte, wrap inside a 32-byte page, or run through the whole array.

The SPI pins are sampled in the system clock domain through a two-stage synchronizer, and SCK edges are found by comparison with a delayed copy. A HOLD input freezes the transfer: SCK edges are ignored while it is low, and the serial output is released. The output enable stands in for the high-impedance state of the serial output pin.

The controller is one state machine. IDLE (chip select high) goes to CMD when chip select falls. CMD decodes the eighth bit and goes to ADDR (read or write), MODE_WR, MODE_RD, or SKIP for an unknown code. ADDR goes to RD or WR after the 24th bit. WR goes to SKIP after its first byte in single-byte mode. MODE_WR goes to SKIP after its byte. RD and MODE_RD go to SKIP on the falling edge after their last bit when no further byte follows. From every state, chip select high returns the machine to IDLE.

Top module: `spi_sram_target`

## Requirements
- R1: While chip select is high the target is idle and the output enable is low. Raising chip select ends any command, and the next frame starts again with a command byte.
- R2: A frame starts with 8 command bits, followed by 24 address bits for read and write, all MSB first and sampled on rising SCK. Address bits above the low ADDR_W bits are ignored.
- R3: The command codes are 0x03 read, 0x02 write, 0x01 write mode register and 0x05 read mode register. Any other code makes the target ignore the rest of the frame, so the output stays disabled and the array is unchanged.
- R4: Mode register bits 7:6 select the mode: 00 single byte, 10 page, 01 sequential (11 acts as sequential). It resets to 01. A read returns the two mode bits in positions 7:6 with zeros below them, and bits 5:0 written to it are ignored.
- R5: In sequential mode the pointer steps by one after each byte, and the last address is followed by address 0.
- R6: In page mode the pointer steps through the low 5 bits only, wrapping from the last byte of a 32-byte page to its first byte, for both reads and writes.
- R7: In single-byte mode exactly one data byte moves after the address. Further SCK pulses neither write the array nor drive the output.
- R8: Read data changes after falling SCK edges, with the MSB of the first byte following the falling edge after the last address bit. The output enable is high only while read or mode-read data is being shifted out.
- R9: While HOLD is low, SCK edges are ignored and the output enable is low. When HOLD returns high, the transfer continues from the bit where it stopped.
- R10: A write byte reaches the array only after all 8 of its bits have arrived. A byte cut short by chip select rising is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the SPI pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low chip select |
| si | input | 1 | Serial data from host |
| hold_n | input | 1 | Active-low pause of the transfer |
| so | output | 1 | Serial read data |
| so_oe | output | 1 | Enable for the serial output pin driver |

## Verification
Every pin change takes effect at the third system clock edge after it: two synchronizer stages plus the edge-detect register. Read data therefore appears three clocks after a falling SCK edge, and a HOLD change reaches the output enable two clocks after the pin. The bench holds each SCK phase for eight system clocks and samples the serial output only at the host's rising SCK edge, well after the value has settled. After each HOLD change it waits six clocks before it pulses SCK or checks the output enable. The expected read bytes are queued before the frame starts and are taken off the queue as each completed byte arrives.

// File: rtl/spi_sram_pkg.sv
package spi_sram_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_ADDR,
        ST_WR,
        ST_RD,
        ST_MODE_WR,
        ST_MODE_RD,
        ST_SKIP
    } st_t;

    typedef enum logic [1:0] {
        MD_BYTE = 2'b00,
        MD_SEQ  = 2'b01,
        MD_PAGE = 2'b10,
        MD_RSVD = 2'b11
    } md_t;

    localparam logic [7:0] OP_READ   = 8'h03;
    localparam logic [7:0] OP_WRITE  = 8'h02;
    localparam logic [7:0] OP_WRMODE = 8'h01;
    localparam logic [7:0] OP_RDMODE = 8'h05;

endpackage

// File: rtl/spi_sram_sync.sv
module spi_sram_sync #(
    parameter int              W       = 4,
    parameter int              STAGES  = 2,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] pipe [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) pipe[i] <= RST_VAL;
        end else begin
            pipe[0] <= d;
            for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/spi_sram_ptr.sv
module spi_sram_ptr
    import spi_sram_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int PAGE_W = 5
) (
    input  logic [ADDR_W-1:0] cur,
    input  md_t               mode,
    output logic [ADDR_W-1:0] nxt
);
    logic [ADDR_W-1:0] inc;

    always_comb begin
        inc = cur + 1'b1;
        if (mode == MD_PAGE) nxt = {cur[ADDR_W-1:PAGE_W], inc[PAGE_W-1:0]};
        else                 nxt = inc;
    end
endmodule

// File: rtl/spi_sram_array.sv
module spi_sram_array #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/spi_sram_target.sv
module spi_sram_target
    import spi_sram_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int PAGE_W = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck,
    input  logic cs_n,
    input  logic si,
    input  logic hold_n,
    output logic so,
    output logic so_oe
);
    localparam int CMD_LAST = 7;
    localparam int ADR_BITS = 24;
    localparam int ADR_LAST = ADR_BITS - 1;
    localparam int CNT_W    = $clog2(ADR_BITS);

    logic [3:0]        sync_q;
    logic              sck_s, csn_s, si_s, hold_s, sck_q;
    logic              live, rise, fall;
    st_t               state_q, state_d;
    md_t               mode_q;
    logic [CNT_W-1:0]  bit_cnt;
    logic [ADR_LAST:0] sh;
    logic [7:0]        in_byte, osh, rdata;
    logic [ADR_LAST:0] full_addr;
    logic [ADDR_W-1:0] ptr_q, nxt_ptr, raddr;
    logic              is_rd, so_q, oe_q, we;

    spi_sram_sync #(.W(4), .STAGES(2), .RST_VAL(4'b1010)) sync_i (
        .clk(clk), .rst_n(rst_n), .d({hold_n, si, cs_n, sck}), .q(sync_q)
    );
    assign {hold_s, si_s, csn_s, sck_s} = sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sck_q <= 1'b0;
        else        sck_q <= sck_s;
    end

    assign live      = !csn_s && hold_s;
    assign rise      = live && sck_s && !sck_q;
    assign fall      = live && !sck_s && sck_q;
    assign in_byte   = {sh[6:0], si_s};
    assign full_addr = {sh[ADR_LAST-1:0], si_s};
    assign we        = rise && (state_q == ST_WR) && (bit_cnt == CNT_W'(CMD_LAST));
    assign raddr     = (state_q == ST_ADDR) ? full_addr[ADDR_W-1:0] : nxt_ptr;

    spi_sram_ptr #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) ptr_i (
        .cur(ptr_q), .mode(mode_q), .nxt(nxt_ptr)
    );

    spi_sram_array #(.ADDR_W(ADDR_W), .DATA_W(8)) array_i (
        .clk(clk), .we(we), .waddr(ptr_q), .wdata(in_byte),
        .raddr(raddr), .rdata(rdata)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (csn_s) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: state_d = ST_CMD;
                ST_CMD: begin
                    if (rise && bit_cnt == CNT_W'(CMD_LAST)) begin
                        case (in_byte)
                            OP_READ, OP_WRITE: state_d = ST_ADDR;
                            OP_WRMODE:         state_d = ST_MODE_WR;
                            OP_RDMODE:         state_d = ST_MODE_RD;
                            default:           state_d = ST_SKIP;
                        endcase
                    end
                end
                ST_ADDR: begin
                    if (rise && bit_cnt == CNT_W'(ADR_LAST))
                        state_d = is_rd ? ST_RD : ST_WR;
                end
                ST_WR: begin
                    if (we && mode_q == MD_BYTE) state_d = ST_SKIP;
                end
                ST_MODE_WR: begin
                    if (rise && bit_cnt == CNT_W'(CMD_LAST)) state_d = ST_SKIP;
                end
                ST_RD, ST_MODE_RD: begin
                    if (fall && bit_cnt == CNT_W'(8)) state_d = ST_SKIP;
                end
                ST_SKIP: state_d = ST_SKIP;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            sh      <= '0;
            is_rd   <= 1'b0;
            ptr_q   <= '0;
            mode_q  <= MD_SEQ;
            osh     <= '0;
            so_q    <= 1'b0;
            oe_q    <= 1'b0;
        end else if (csn_s) begin
            bit_cnt <= '0;
            oe_q    <= 1'b0;
        end else begin
            if (rise) sh <= full_addr;
            case (state_q)
                ST_CMD: if (rise) begin
                    if (bit_cnt == CNT_W'(CMD_LAST)) begin
                        bit_cnt <= '0;
                        is_rd   <= (in_byte == OP_READ);
                        osh     <= {mode_q, 6'b0};
                    end else begin
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                end
                ST_ADDR: if (rise) begin
                    if (bit_cnt == CNT_W'(ADR_LAST)) begin
                        bit_cnt <= '0;
                        ptr_q   <= full_addr[ADDR_W-1:0];
                        osh     <= rdata;
                    end else begin
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                end
                ST_WR: if (rise) begin
                    if (bit_cnt == CNT_W'(CMD_LAST)) begin
                        bit_cnt <= '0;
                        ptr_q   <= nxt_ptr;
                    end else begin
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                end
                ST_MODE_WR: if (rise) begin
                    bit_cnt <= bit_cnt + 1'b1;
                    if (bit_cnt == CNT_W'(CMD_LAST)) mode_q <= md_t'(in_byte[7:6]);
                end
                ST_RD, ST_MODE_RD: if (fall) begin
                    if (bit_cnt == CNT_W'(8)) begin
                        oe_q <= 1'b0;
                    end else begin
                        so_q <= osh[7];
                        oe_q <= 1'b1;
                        osh  <= {osh[6:0], 1'b0};
                        if (bit_cnt == CNT_W'(CMD_LAST) && state_q == ST_RD
                            && mode_q != MD_BYTE) begin
                            bit_cnt <= '0;
                            ptr_q   <= nxt_ptr;
                            osh     <= rdata;
                        end else begin
                            bit_cnt <= bit_cnt + 1'b1;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        so    = so_q;
        so_oe = oe_q && hold_s && !csn_s;
    end
endmodule

// File: rtl/spi_sram_target_chk.sv
module spi_sram_target_chk
    import spi_sram_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int PAGE_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              csn_s,
    input logic              hold_s,
    input logic              so_oe,
    input logic              we,
    input st_t               state_q,
    input md_t               mode_q,
    input logic [4:0]        bit_cnt,
    input logic [ADDR_W-1:0] ptr_q
);
    a_r1_cs_idle: assert property (@(posedge clk) disable iff (!rst_n)
        csn_s |=> state_q == ST_IDLE);

    a_r8_oe_only_reading: assert property (@(posedge clk) disable iff (!rst_n)
        so_oe |-> (state_q == ST_RD || state_q == ST_MODE_RD));

    a_r4_mode_only_by_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mode_q) |-> $past(state_q) == ST_MODE_WR);

    a_r5_ptr_moves_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> !$stable(ptr_q));

    a_r6_page_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (we && mode_q == MD_PAGE) |=>
            ptr_q[ADDR_W-1:PAGE_W] == $past(ptr_q[ADDR_W-1:PAGE_W]));

    a_r9_hold_freezes: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold_s && !csn_s && state_q != ST_IDLE) |=>
            ($stable(state_q) && $stable(bit_cnt)));
endmodule

bind spi_sram_target spi_sram_target_chk #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .csn_s(csn_s), .hold_s(hold_s), .so_oe(so_oe),
    .we(we), .state_q(state_q), .mode_q(mode_q), .bit_cnt(bit_cnt), .ptr_q(ptr_q)
);

// File: tb/spi_sram_target_tb_top.sv
module spi_sram_target_tb_top;
    localparam int CLK_P = 10;
    localparam int HALF  = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sck = 1'b0, cs_n = 1'b1, si = 1'b0, hold_n = 1'b1;
    logic so, so_oe;

    int total = 0, bad = 0;
    int mcnt = 0, frame_bytes = 0, oe_cnt = 0, hold_oe = 0;
    logic [7:0] mbits = '0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #(CLK_P/2) clk = ~clk;

    spi_sram_target dut_i (
        .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si),
        .hold_n(hold_n), .so(so), .so_oe(so_oe)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // monitor: assembles read bytes and compares against the scoreboard
    always @(posedge sck) begin
        if (!cs_n && so_oe) oe_cnt++;
        if (!hold_n && so_oe) hold_oe++;
        if (!cs_n && so_oe) begin
            mbits = {mbits[6:0], so};
            mcnt++;
            if (mcnt == 8) begin
                mcnt = 0;
                frame_bytes++;
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R8 unexpected byte", mbits, 0);
                end else begin
                    logic [7:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    chk(mbits == e, t, mbits, e);
                end
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bit_out(input logic b);
        @(negedge clk) si = b;
        tick(HALF); sck = 1'b1;
        tick(HALF); sck = 1'b0;
    endtask

    task automatic send8(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) bit_out(b[i]);
    endtask

    task automatic send24(input logic [23:0] a);
        for (int i = 23; i >= 0; i--) bit_out(a[i]);
    endtask

    task automatic start();
        tick(4); cs_n = 1'b0;
        mcnt = 0; frame_bytes = 0; oe_cnt = 0; hold_oe = 0;
        tick(6);
    endtask

    task automatic stop();
        tick(4); cs_n = 1'b1; tick(8);
    endtask

    // driver: pushes expected bytes before the frame runs
    task automatic expect_bytes(input logic [7:0] e[$], input string tag);
        foreach (e[i]) begin
            exp_q.push_back(e[i]);
            tag_q.push_back(tag);
        end
    endtask

    task automatic do_write(input logic [23:0] a, input logic [7:0] d[$]);
        start(); send8(8'h02); send24(a);
        foreach (d[i]) send8(d[i]);
        stop();
    endtask

    task automatic do_read(input logic [23:0] a, input int n, input logic [7:0] e[$],
                           input string tag);
        expect_bytes(e, tag);
        start(); send8(8'h03); send24(a);
        repeat (n) send8(8'h00);
        stop();
        chk(frame_bytes == e.size(), tag, frame_bytes, e.size());
        chk(exp_q.size() == 0, tag, exp_q.size(), 0);
        exp_q.delete(); tag_q.delete();
    endtask

    task automatic mode_wr(input logic [7:0] m);
        start(); send8(8'h01); send8(m); stop();
    endtask

    task automatic mode_rd(input logic [7:0] e, input string tag);
        expect_bytes('{e}, tag);
        start(); send8(8'h05); send8(8'h00); stop();
        chk(frame_bytes == 1, tag, frame_bytes, 1);
        exp_q.delete(); tag_q.delete();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 1);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        tick(5); rst_n = 1'b1; tick(5);
        chk(so_oe == 1'b0, "R1 output disabled after reset", so_oe, 0);

        // R4 reset value of mode register
        mode_rd(8'h40, "R4 mode reset value");

        // R2 upper address bits ignored, R5 rollover at the top
        do_write(24'hFE07FE, '{8'hA1, 8'hA2, 8'hA3, 8'hA4});
        chk(oe_cnt == 0, "R8 no output during write", oe_cnt, 0);
        do_read(24'h0007FE, 4, '{8'hA1, 8'hA2, 8'hA3, 8'hA4}, "R5 sequential rollover");
        do_read(24'h000000, 1, '{8'hA3}, "R2 R5 wrapped byte at zero");

        // R6 page mode
        mode_wr(8'h80);
        mode_rd(8'h80, "R4 page mode readback");
        do_write(24'h00003E, '{8'hB0, 8'hB1, 8'hB2, 8'hB3});
        do_read(24'h000020, 2, '{8'hB2, 8'hB3}, "R6 write wrapped in page");
        do_read(24'h00003E, 3, '{8'hB0, 8'hB1, 8'hB2}, "R6 read wrapped in page");

        // R4 low bits ignored, back to sequential
        mode_wr(8'h7F);
        mode_rd(8'h40, "R4 low bits read as zero");
        do_write(24'h000100, '{8'h11, 8'h22});
        do_write(24'h000200, '{8'h33, 8'h44});

        // R7 single byte mode
        mode_wr(8'h00);
        do_write(24'h000100, '{8'hC1, 8'hC2});
        do_read(24'h000100, 2, '{8'hC1}, "R7 single byte read");
        mode_wr(8'h40);
        do_read(24'h000100, 2, '{8'hC1, 8'h22}, "R7 second byte not written");

        // R10 partial byte dropped
        start(); send8(8'h02); send24(24'h000201);
        repeat (5) bit_out(1'b1);
        stop();
        do_read(24'h000201, 1, '{8'h44}, "R10 partial byte dropped");

        // R3 unknown command ignores frame
        start(); send8(8'h77); send8(8'h02); send24(24'h000200); send8(8'h99);
        stop();
        chk(oe_cnt == 0, "R3 no output after unknown code", oe_cnt, 0);
        do_read(24'h000200, 1, '{8'h33}, "R3 array unchanged");

        // R9 hold during write
        start(); send8(8'h02); send24(24'h000300);
        for (int i = 7; i >= 4; i--) bit_out(logic'((8'hC3 >> i) & 1));
        @(negedge clk) hold_n = 1'b0; tick(6);
        repeat (3) bit_out(1'b0);
        @(negedge clk) hold_n = 1'b1; tick(6);
        for (int i = 3; i >= 0; i--) bit_out(logic'((8'hC3 >> i) & 1));
        send8(8'hD4);
        stop();

        // R9 hold during read
        expect_bytes('{8'hC3, 8'hD4}, "R9 read across hold");
        start(); send8(8'h03); send24(24'h000300);
        repeat (4) bit_out(1'b0);
        @(negedge clk) hold_n = 1'b0; tick(6);
        chk(so_oe == 1'b0, "R9 output off in hold", so_oe, 0);
        repeat (3) bit_out(1'b1);
        @(negedge clk) hold_n = 1'b1; tick(6);
        repeat (12) bit_out(1'b0);
        stop();
        chk(frame_bytes == 2, "R9 bytes across hold", frame_bytes, 2);
        chk(hold_oe == 0, "R9 no output edges in hold", hold_oe, 0);
        chk(exp_q.size() == 0, "R9 scoreboard drained", exp_q.size(), 0);
        chk(so_oe == 1'b0, "R1 output off after frame", so_oe, 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule